// File: doc/BRIEF.md
# Memory-Mapped Control and Status Register Bank

This block decodes a simple valid/ready CPU bus carrying a byte address, write data and a byte write strobe. An access with any strobe bit set is a write. An access with an all-zero strobe is a read. Behind the bus sit registers of three kinds.

The first kind is stored in the bank. This covers a single mode register and a table of `2**LOG2_ITEMS` entries. Every table entry is driven out at the same time on its own slice of a flattened output vector, so user logic sees all entries in parallel. The second kind is pass-through: the bank keeps no copy, and hands the write data and a one-cycle write enable straight to user logic, which can stall the bus. The third kind is read sources, which the bank never stores. A plain status input is muxed onto the read path. A handshaked pop port lets user logic supply read data later.

The bank also exports the current bus address and handshake on every cycle. User logic can use these to tell which table entry, or which other register, is being touched.

Top module: `csr_bank`

## Requirements
- R1: After reset, `mode_q_o` equals `MODE_RST`, every table entry equals `TAB_RST`, and `rsp_rvalid_o` is low.
- R2: Table entry i decodes the byte window from `TAB_BASE + 4*i` up to, but not including, `TAB_BASE + 4*(i+1)`. A write into that window updates only entry i. Entry i is visible at all times on `tab_q_o[i*TAB_W +: TAB_W]`.
- R3: A stored register changes only on a cycle where valid and ready are both high, at least one strobe bit is set, and the address is in its window. An access with an all-zero strobe changes no stored register.
- R4: Strobe bit b writes bits 8b to 8b+7 of a stored register. Strobe bits for bytes that lie wholly above the register width have no effect.
- R5: Writes to the 4-byte window at `MODE_ADDR` (default 0x00) are stored in `mode_q_o`. Reads of that window return `mode_rd_i` zero-extended, not the stored value.
- R6: A write to the window at `CMD_ADDR` (default 0x04) drives `cmd_wen_o` high in the same cycle as acceptance, and drives `cmd_wdata_o` with the bus write data. While such a write is presented, `req_ready_o` follows `cmd_wready_i`.
- R7: A read of the window at `STAT_ADDR` (default 0x08) returns `stat_i`, with the bits above `STAT_W` equal to zero.
- R8: An accepted read of any address other than the pop window sets `rsp_rvalid_o` for exactly one cycle, starting with the clock edge that accepts it. Addresses with no read source, including the mode-less table window, return zero. Writes produce no response.
- R9: A read of the window at `POP_ADDR` (default 0x0C) has `req_ready_o` follow `pop_rready_i`, and pulses `pop_ren_o` in the acceptance cycle. The bus then stays not-ready until `pop_rvalid_i` is seen. `pop_rdata_i` is returned with `rsp_rvalid_o` one cycle after that.
- R10: `acc_addr_o` equals `req_addr_i`, `acc_fire_o` equals valid AND ready, and `acc_write_o` is the OR of the strobe, on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request accepted when high with valid |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| req_wstrb_i | input | DATA_W/8 | Byte write strobe; all zero means read |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_rvalid_o | output | 1 | Read data valid, one cycle |
| acc_addr_o | output | ADDR_W | Exported bus address |
| acc_fire_o | output | 1 | Exported handshake (valid AND ready) |
| acc_write_o | output | 1 | Exported write indication |
| mode_q_o | output | MODE_W | Stored mode register |
| mode_rd_i | input | MODE_W | Read half of the mode register, from user logic |
| tab_q_o | output | 2**LOG2_ITEMS * TAB_W | All table entries, entry i in slice i |
| cmd_wdata_o | output | DATA_W | Pass-through write data |
| cmd_wen_o | output | 1 | Pass-through write enable |
| cmd_wready_i | input | 1 | User logic ready for pass-through write |
| stat_i | input | STAT_W | Status value from user logic |
| pop_ren_o | output | 1 | Pop read enable |
| pop_rdata_i | input | DATA_W | Pop read data |
| pop_rvalid_i | input | 1 | Pop read data valid |
| pop_rready_i | input | 1 | User logic ready to accept a pop |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- No stored register moves without an accepted write, and a zero-strobe access never moves one.
- At most one table entry is enabled at a time.
- A non-pop read is always answered on the next cycle.
- The bus is stalled right after a pop is accepted.
- A pass-through enable never appears without user ready.

Only the bench scenarios can show that the right bytes land in the right entry for each window offset and strobe pattern, and that the mode read half returns the input rather than the stored value. The same applies to the zero-extension of status data and to the delayed pop response carrying the user's data.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_CMD,
    SEL_STAT,
    SEL_POP,
    SEL_TAB
  } csr_sel_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SPAN      = 4,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR  = 4,
  parameter int STAT_ADDR = 8,
  parameter int POP_ADDR  = 12,
  parameter int TAB_BASE  = 16,
  parameter int N_ITEMS   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_e          sel_o
);

  localparam int TAB_END = TAB_BASE + N_ITEMS * SPAN;

  int a;

  always_comb begin
    a = int'(addr_i);
    if (a >= MODE_ADDR && a < MODE_ADDR + SPAN)      sel_o = SEL_MODE;
    else if (a >= CMD_ADDR && a < CMD_ADDR + SPAN)   sel_o = SEL_CMD;
    else if (a >= STAT_ADDR && a < STAT_ADDR + SPAN) sel_o = SEL_STAT;
    else if (a >= POP_ADDR && a < POP_ADDR + SPAN)   sel_o = SEL_POP;
    else if (a >= TAB_BASE && a < TAB_END)           sel_o = SEL_TAB;
    else                                             sel_o = SEL_NONE;
  end

endmodule

// File: rtl/csr_store_reg.sv
module csr_store_reg #(
  parameter int           W      = 8,
  parameter logic [W-1:0] RST    = '0,
  parameter int           ADDR_W = 8,
  parameter int           STRB_W = 4,
  parameter int           BASE   = 0,
  parameter int           SPAN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  output logic              wen_o,
  output logic [W-1:0]      q_o
);

  logic hit;

  always_comb begin
    hit   = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + SPAN);
    wen_o = fire_i & hit & (|wstrb_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= RST;
    end else if (wen_o) begin
      for (int i = 0; i < W; i++) begin
        if (wstrb_i[i/8]) q_o[i] <= wdata_i[i];
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> $stable(q_o));

  // R3
  zero_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_i && wstrb_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/csr_resp.sv
module csr_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              pop_start_i,
  input  logic              pop_rvalid_i,
  input  logic [DATA_W-1:0] pop_rdata_i,
  output logic              pending_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= 1'b0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
    end else begin
      rvalid_o <= 1'b0;
      if (pending_o) begin
        if (pop_rvalid_i) begin
          pending_o <= 1'b0;
          rvalid_o  <= 1'b1;
          rdata_o   <= pop_rdata_i;
        end
      end else if (pop_start_i) begin
        pending_o <= 1'b1;
      end else if (rd_fire_i) begin
        rvalid_o <= 1'b1;
        rdata_o  <= rd_data_i;
      end
    end
  end

  // R8
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_fire_i && !pending_o) |=> rvalid_o);

  // R9
  pop_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (pending_o && !pop_rvalid_i) |=> !rvalid_o);

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                MODE_W     = 12,
  parameter logic [MODE_W-1:0] MODE_RST   = 12'h5A5,
  parameter int                TAB_W      = 16,
  parameter logic [TAB_W-1:0]  TAB_RST    = 16'hC0DE,
  parameter int                LOG2_ITEMS = 2,
  parameter int                STAT_W     = 20,
  parameter int                MODE_ADDR  = 0,
  parameter int                CMD_ADDR   = 4,
  parameter int                STAT_ADDR  = 8,
  parameter int                POP_ADDR   = 12,
  parameter int                TAB_BASE   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  input  logic [DATA_W/8-1:0]         req_wstrb_i,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        rsp_rvalid_o,
  output logic [ADDR_W-1:0]           acc_addr_o,
  output logic                        acc_fire_o,
  output logic                        acc_write_o,
  output logic [MODE_W-1:0]           mode_q_o,
  input  logic [MODE_W-1:0]           mode_rd_i,
  output logic [(1<<LOG2_ITEMS)*TAB_W-1:0] tab_q_o,
  output logic [DATA_W-1:0]           cmd_wdata_o,
  output logic                        cmd_wen_o,
  input  logic                        cmd_wready_i,
  input  logic [STAT_W-1:0]           stat_i,
  output logic                        pop_ren_o,
  input  logic [DATA_W-1:0]           pop_rdata_i,
  input  logic                        pop_rvalid_i,
  input  logic                        pop_rready_i
);

  localparam int N_ITEMS = 1 << LOG2_ITEMS;
  localparam int STRB_W  = DATA_W / 8;

  csr_sel_e            sel;
  logic                is_wr;
  logic                fire;
  logic                pending;
  logic                rd_fire;
  logic [DATA_W-1:0]   rd_data;
  logic                mode_wen;
  logic [N_ITEMS-1:0]  tab_wen;

  csr_decode #(
    .ADDR_W(ADDR_W), .SPAN(STRB_W), .MODE_ADDR(MODE_ADDR), .CMD_ADDR(CMD_ADDR),
    .STAT_ADDR(STAT_ADDR), .POP_ADDR(POP_ADDR), .TAB_BASE(TAB_BASE), .N_ITEMS(N_ITEMS)
  ) u_decode (
    .addr_i(req_addr_i),
    .sel_o (sel)
  );

  always_comb begin
    is_wr = |req_wstrb_i;
    if (pending)                        req_ready_o = 1'b0;
    else if (sel == SEL_CMD && is_wr)   req_ready_o = cmd_wready_i;
    else if (sel == SEL_POP && !is_wr)  req_ready_o = pop_rready_i;
    else                                req_ready_o = 1'b1;
    fire        = req_valid_i & req_ready_o;
    acc_addr_o  = req_addr_i;
    acc_fire_o  = fire;
    acc_write_o = is_wr;
    cmd_wdata_o = req_wdata_i;
    cmd_wen_o   = fire & is_wr & (sel == SEL_CMD);
    pop_ren_o   = fire & !is_wr & (sel == SEL_POP);
    rd_fire     = fire & !is_wr & (sel != SEL_POP);
    rd_data     = '0;
    case (sel)
      SEL_MODE: rd_data[MODE_W-1:0] = mode_rd_i;
      SEL_STAT: rd_data[STAT_W-1:0] = stat_i;
      default:  rd_data = '0;
    endcase
  end

  csr_store_reg #(
    .W(MODE_W), .RST(MODE_RST), .ADDR_W(ADDR_W), .STRB_W(STRB_W),
    .BASE(MODE_ADDR), .SPAN(STRB_W)
  ) u_mode (
    .clk(clk), .rst(rst), .fire_i(fire), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i[MODE_W-1:0]), .wstrb_i(req_wstrb_i),
    .wen_o(mode_wen), .q_o(mode_q_o)
  );

  for (genvar g = 0; g < N_ITEMS; g++) begin : g_tab
    csr_store_reg #(
      .W(TAB_W), .RST(TAB_RST), .ADDR_W(ADDR_W), .STRB_W(STRB_W),
      .BASE(TAB_BASE + g * STRB_W), .SPAN(STRB_W)
    ) u_entry (
      .clk(clk), .rst(rst), .fire_i(fire), .addr_i(req_addr_i),
      .wdata_i(req_wdata_i[TAB_W-1:0]), .wstrb_i(req_wstrb_i),
      .wen_o(tab_wen[g]), .q_o(tab_q_o[g*TAB_W +: TAB_W])
    );
  end

  csr_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .rd_fire_i(rd_fire), .rd_data_i(rd_data),
    .pop_start_i(pop_ren_o), .pop_rvalid_i(pop_rvalid_i), .pop_rdata_i(pop_rdata_i),
    .pending_o(pending), .rvalid_o(rsp_rvalid_o), .rdata_o(rsp_rdata_o)
  );

  // R2
  one_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tab_wen, mode_wen}));

  // R3
  tab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid_i && req_ready_o && (|req_wstrb_i)) |=> $stable(tab_q_o));

  // R6
  cmd_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wen_o |-> cmd_wready_i);

  // R9
  pop_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pop_ren_o |=> !req_ready_o);

endmodule

// File: tb/csr_bank_test.sv
`timescale 1ns/1ps
module csr_bank_test;

  localparam int N  = 4;
  localparam int TW = 16;
  localparam int MW = 12;
  localparam int SW = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst;
  logic              req_valid_i, req_ready_o;
  logic [7:0]        req_addr_i;
  logic [31:0]       req_wdata_i;
  logic [3:0]        req_wstrb_i;
  logic [31:0]       rsp_rdata_o;
  logic              rsp_rvalid_o;
  logic [7:0]        acc_addr_o;
  logic              acc_fire_o, acc_write_o;
  logic [MW-1:0]     mode_q_o, mode_rd_i;
  logic [N*TW-1:0]   tab_q_o;
  logic [31:0]       cmd_wdata_o;
  logic              cmd_wen_o, cmd_wready_i;
  logic [SW-1:0]     stat_i;
  logic              pop_ren_o;
  logic [31:0]       pop_rdata_i;
  logic              pop_rvalid_i, pop_rready_i;

  csr_bank uut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_wstrb_i(req_wstrb_i),
    .rsp_rdata_o(rsp_rdata_o), .rsp_rvalid_o(rsp_rvalid_o), .acc_addr_o(acc_addr_o),
    .acc_fire_o(acc_fire_o), .acc_write_o(acc_write_o), .mode_q_o(mode_q_o),
    .mode_rd_i(mode_rd_i), .tab_q_o(tab_q_o), .cmd_wdata_o(cmd_wdata_o),
    .cmd_wen_o(cmd_wen_o), .cmd_wready_i(cmd_wready_i), .stat_i(stat_i),
    .pop_ren_o(pop_ren_o), .pop_rdata_i(pop_rdata_i), .pop_rvalid_i(pop_rvalid_i),
    .pop_rready_i(pop_rready_i)
  );

  int checks = 0;
  int fails  = 0;

  logic [MW-1:0] exp_mode;
  logic [TW-1:0] exp_tab [N];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d,
                                        logic [3:0] s, int w);
    logic [31:0] r = old;
    for (int i = 0; i < w; i++) if (s[i/8]) r[i] = d[i];
    return r;
  endfunction

  task automatic check_state(string req);
    chk({req, " mode"}, 64'(mode_q_o), 64'(exp_mode));
    for (int i = 0; i < N; i++)
      chk({req, " table"}, 64'(tab_q_o[i*TW +: TW]), 64'(exp_tab[i]));
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d, logic [3:0] s);
    if (s == 4'b0) return;
    if (a < 8'd4) exp_mode = MW'(merge(32'(exp_mode), d, s, MW));
    else if (a >= 8'd16 && a < 8'd32)
      exp_tab[(a - 8'd16) / 4] = TW'(merge(32'(exp_tab[(a - 8'd16) / 4]), d, s, TW));
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_wdata_i = d; req_wstrb_i = s;
    @(posedge clk); #1;
    req_valid_i = 1'b0; req_wstrb_i = 4'b0;
    model_write(a, d, s);
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d, output logic rv);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_wstrb_i = 4'b0;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    d = rsp_rdata_o; rv = rsp_rvalid_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    void'($urandom(32'd20240911));
    rst = 1'b1; req_valid_i = 0; req_addr_i = 0; req_wdata_i = 0; req_wstrb_i = 0;
    mode_rd_i = 0; cmd_wready_i = 1; stat_i = 0; pop_rdata_i = 0;
    pop_rvalid_i = 0; pop_rready_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    exp_mode = 12'h5A5;
    for (int i = 0; i < N; i++) exp_tab[i] = 16'hC0DE;
    check_state("R1");
    chk("R1 rvalid", 64'(rsp_rvalid_o), 64'd0);

    // R2 each entry distinct value, only addressed entry changes
    for (int i = 0; i < N; i++) begin
      do_write(8'(16 + 4 * i), 32'h1111 * (i + 1), 4'b0011);
      check_state("R2");
      chk("R8 no write response", 64'(rsp_rvalid_o), 64'd0);
    end
    // R2 byte offset inside window still selects the entry
    do_write(8'd23, 32'h0000_BEEF, 4'b0011);
    check_state("R2 offset");
    chk("R2 entry1", 64'(tab_q_o[TW +: TW]), 64'h0000BEEF);

    // R4 per byte strobe, upper bytes beyond width ignored
    do_write(8'd24, 32'h1234_5678, 4'b0010);
    chk("R4 byte1", 64'(tab_q_o[2*TW +: TW]), 64'h5633);
    do_write(8'd24, 32'hFFFF_FFFF, 4'b1100);
    chk("R4 upper", 64'(tab_q_o[2*TW +: TW]), 64'h5633);
    check_state("R4");

    // R3 zero strobe leaves everything unchanged
    do_write(8'd16, 32'hFFFF_FFFF, 4'b0000);
    check_state("R3 zero strobe");
    // R8 table window is unreadable: returns zero
    chk("R8 table read valid", 64'(rsp_rvalid_o), 64'd1);
    chk("R8 table read zero", 64'(rsp_rdata_o), 64'd0);
    @(posedge clk); #1;
    chk("R8 one cycle", 64'(rsp_rvalid_o), 64'd0);

    // R5 mode write stored, read returns input half
    do_write(8'd0, 32'hFFFF_F00D, 4'b1111);
    check_state("R5 write");
    mode_rd_i = 12'hABC;
    do_read(8'd0, rd, rv);
    chk("R5 read valid", 64'(rv), 64'd1);
    chk("R5 read data", 64'(rd), 64'h0ABC);
    check_state("R5 hold");

    // R7 status zero-extended
    stat_i = 20'hFEDCB;
    do_read(8'd9, rd, rv);
    chk("R7 valid", 64'(rv), 64'd1);
    chk("R7 data", 64'(rd), 64'h000FEDCB);

    // R10 export, R6 pass-through with stall
    @(negedge clk);
    cmd_wready_i = 1'b0;
    req_valid_i = 1'b1; req_addr_i = 8'd4; req_wdata_i = 32'hCAFE_0123; req_wstrb_i = 4'b1111;
    #1;
    chk("R6 stall ready", 64'(req_ready_o), 64'd0);
    chk("R6 stall wen", 64'(cmd_wen_o), 64'd0);
    chk("R10 addr", 64'(acc_addr_o), 64'd4);
    chk("R10 fire low", 64'(acc_fire_o), 64'd0);
    chk("R10 write", 64'(acc_write_o), 64'd1);
    @(negedge clk);
    cmd_wready_i = 1'b1;
    #1;
    chk("R6 wen", 64'(cmd_wen_o), 64'd1);
    chk("R6 wdata", 64'(cmd_wdata_o), 64'hCAFE0123);
    chk("R10 fire", 64'(acc_fire_o), 64'd1);
    @(posedge clk); #1;
    req_valid_i = 1'b0; req_wstrb_i = 4'b0;
    check_state("R6 no store");

    // R9 pop handshake
    @(negedge clk);
    pop_rready_i = 1'b0;
    req_valid_i = 1'b1; req_addr_i = 8'd12; req_wstrb_i = 4'b0;
    #1;
    chk("R9 ready follows", 64'(req_ready_o), 64'd0);
    chk("R9 no ren", 64'(pop_ren_o), 64'd0);
    @(negedge clk);
    pop_rready_i = 1'b1;
    #1;
    chk("R9 ren", 64'(pop_ren_o), 64'd1);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    chk("R9 no early rvalid", 64'(rsp_rvalid_o), 64'd0);
    req_valid_i = 1'b1; req_addr_i = 8'd8;
    #1;
    chk("R9 stalled", 64'(req_ready_o), 64'd0);
    req_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 still waiting", 64'(rsp_rvalid_o), 64'd0);
    @(negedge clk);
    pop_rvalid_i = 1'b1; pop_rdata_i = 32'h9ABC_DEF0;
    @(posedge clk); #1;
    pop_rvalid_i = 1'b0;
    chk("R9 rvalid", 64'(rsp_rvalid_o), 64'd1);
    chk("R9 data", 64'(rsp_rdata_o), 64'h9ABCDEF0);
    chk("R9 ready back", 64'(req_ready_o), 64'd1);
    @(posedge clk); #1;
    chk("R9 one cycle", 64'(rsp_rvalid_o), 64'd0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          do_write(8'(16 + 4 * ($urandom % N) + ($urandom % 4)), $urandom, 4'($urandom));
          check_state("R2 R4 random");
        end
        1: begin
          do_write(8'($urandom % 4), $urandom, 4'($urandom));
          check_state("R5 R4 random");
        end
        2: begin
          stat_i = SW'($urandom);
          do_read(8'(8 + $urandom % 4), rd, rv);
          chk("R7 random", 64'(rd), 64'(stat_i));
          chk("R8 random valid", 64'(rv), 64'd1);
        end
        default: begin
          do_read(8'(32 + $urandom % 224), rd, rv);
          chk("R8 unmapped", 64'(rd), 64'd0);
          check_state("R3 read");
        end
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule